// File: doc/BRIEF.md
# Sliding-Window Output Fitness Scorer

This block grades how closely the outputs of a circuit under test follow a known response. A response pattern of `EXP_LEN` bits (100 by default) is loaded into a holding register. After a start pulse, the block records `CAP_LEN` beats (110 by default) from `NUM_STREAMS` observed outputs (4 by default), one bit per output on each beat. The recording is longer than the pattern, so the block can tolerate an unknown delay before the response appears.

Each output is then compared with the pattern at every alignment that fits inside the recording, one alignment per clock. For each alignment the block counts the bits that agree, and it keeps the best alignment for each output. The best output overall is reported as a percentage of correct bits, together with which output won and at what alignment. A one-cycle done strobe marks the results as valid.

The observed data enters through a valid/ready stream. The source may hold data back by lowering `obs_valid` for any number of cycles, and no beat is lost or repeated. The block raises `obs_ready` only while it is recording and drops it right after the last beat it needs. A beat moves only in a cycle where both `obs_valid` and `obs_ready` are high. Control pins and result pins are plain levels and pulses.

Top module: `fit_window_scorer`

## Requirements
- R1: After reset, `obs_ready` and `done` are low, and `fitness_pct`, `best_stream` and `best_offset` are zero.
- R2: A `start` pulse while idle raises `obs_ready` from the next cycle. While idle, `obs_ready` stays low whatever `obs_valid` does. Bit s of `obs_bits` belongs to stream s.
- R3: A beat is accepted only on a cycle with `obs_valid` and `obs_ready` both high. Gaps in `obs_valid` neither drop nor repeat beats. `obs_ready` falls right after the `CAP_LEN`-th accepted beat and at no other time.
- R4: `exp_load` while idle stores `exp_data`, and bit i is expected bit i. `exp_load` during capture or scoring has no effect. The stored pattern persists across runs.
- R5: Alignment k (0 to `CAP_LEN-EXP_LEN`) compares expected bit i with accepted beat i+k of a stream, for i from 0 to `EXP_LEN-1`. Beat 0 is the first accepted beat.
- R6: The score of a stream is the highest agreement count over all alignments. The result is the highest stream score, reported as floor(count*100/`EXP_LEN`).
- R7: When scores tie, the lowest stream index wins first and then the lowest alignment. `best_stream` and `best_offset` report the winner.
- R8: `done` is high for exactly one cycle, and the results change only in that cycle. They then hold until the next `done`.
- R9: A `start` pulse during capture or scoring has no effect. The run in progress completes, and no new capture follows.
- R10: Whenever `done` is high, `fitness_pct` is at most 100 and `best_offset` is at most `CAP_LEN-EXP_LEN`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a capture when idle |
| exp_load | input | 1 | Load the expected pattern when idle |
| exp_data | input | EXP_LEN | Expected pattern, bit i is expected bit i |
| obs_valid | input | 1 | Observed beat present |
| obs_ready | output | 1 | Block accepts an observed beat |
| obs_bits | input | NUM_STREAMS | One observed bit per stream |
| done | output | 1 | One-cycle strobe, results valid |
| fitness_pct | output | 7 | Best percentage of matching bits |
| best_stream | output | SW | Index of the winning stream |
| best_offset | output | OW | Alignment of the winning window |

## Verification
The assertions check, on every cycle, that `done` never lasts two cycles and that results move only when `done` is high. They also check that `obs_ready` falls only on an accepted beat and that the reported percentage and alignment stay within range. Only the bench scenarios can show that the counts, the choice of winner and the tie rules are correct. The same goes for the rule that back-pressure gaps do not shift data, and for the rule that a stray start or pattern load during a run is ignored. The bench compares all of these against its own model of the window search.

// File: rtl/fit_pkg.sv
package fit_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CAPT  = 2'd1,
    ST_SCORE = 2'd2,
    ST_FIN   = 2'd3
  } fit_state_e;

  function automatic int width_of(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/fit_ctrl.sv
module fit_ctrl
  import fit_pkg::*;
#(
  parameter int CAP_LEN  = 110,
  parameter int NUM_OFFS = 11,
  parameter int BW       = 7,
  parameter int OW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          obs_valid,
  output fit_state_e    state_o,
  output logic [BW-1:0] beat_idx,
  output logic          beat_we,
  output logic [OW-1:0] offset,
  output logic          score_en,
  output logic          score_first,
  output logic          fin
);
  localparam logic [BW-1:0] LAST_BEAT = BW'(CAP_LEN - 1);
  localparam logic [OW-1:0] LAST_OFF  = OW'(NUM_OFFS - 1);

  fit_state_e state_q;
  logic [BW-1:0] beat_q;
  logic [OW-1:0] off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      off_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_CAPT;
            beat_q  <= '0;
          end
        end
        ST_CAPT: begin
          if (obs_valid) begin
            if (beat_q == LAST_BEAT) begin
              state_q <= ST_SCORE;
              off_q   <= '0;
            end else begin
              beat_q <= beat_q + 1'b1;
            end
          end
        end
        ST_SCORE: begin
          if (off_q == LAST_OFF) state_q <= ST_FIN;
          else                   off_q   <= off_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o     = state_q;
  assign beat_idx    = beat_q;
  assign beat_we     = (state_q == ST_CAPT) && obs_valid;
  assign offset      = off_q;
  assign score_en    = (state_q == ST_SCORE);
  assign score_first = (state_q == ST_SCORE) && (off_q == '0);
  assign fin         = (state_q == ST_FIN);
endmodule

// File: rtl/fit_capture.sv
module fit_capture #(
  parameter int NUM_STREAMS = 4,
  parameter int CAP_LEN     = 110,
  parameter int BW          = 7
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [BW-1:0]                  idx,
  input  logic [NUM_STREAMS-1:0]         bits,
  output logic [NUM_STREAMS*CAP_LEN-1:0] cap_o
);
  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_lane
    logic [CAP_LEN-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (!rst_n)  lane_q      <= '0;
      else if (we) lane_q[idx] <= bits[s];
    end
    assign cap_o[s*CAP_LEN +: CAP_LEN] = lane_q;
  end
endmodule

// File: rtl/fit_popcount.sv
module fit_popcount #(
  parameter int W  = 100,
  parameter int CW = 7
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < W; i++) count = count + CW'(vec[i]);
  end
endmodule

// File: rtl/fit_stream_best.sv
module fit_stream_best #(
  parameter int EXP_LEN = 100,
  parameter int CAP_LEN = 110,
  parameter int OW      = 4,
  parameter int CW      = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CAP_LEN-1:0] lane,
  input  logic [EXP_LEN-1:0] pattern,
  input  logic [OW-1:0]      offset,
  input  logic               en,
  input  logic               first,
  output logic [CW-1:0]      best_cnt,
  output logic [OW-1:0]      best_off
);
  logic [CAP_LEN-1:0] shifted;
  logic [EXP_LEN-1:0] agree;
  logic [CW-1:0]      cnt;

  assign shifted = lane >> offset;
  assign agree   = ~(shifted[EXP_LEN-1:0] ^ pattern);

  fit_popcount #(.W(EXP_LEN), .CW(CW)) u_pop (
    .vec   (agree),
    .count (cnt)
  );

  // strict greater-than keeps the lowest alignment on a tie
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      best_cnt <= '0;
      best_off <= '0;
    end else if (en && (first || cnt > best_cnt)) begin
      best_cnt <= cnt;
      best_off <= offset;
    end
  end
endmodule

// File: rtl/fit_window_scorer.sv
module fit_window_scorer
  import fit_pkg::*;
#(
  parameter int EXP_LEN     = 100,
  parameter int CAP_LEN     = 110,
  parameter int NUM_STREAMS = 4,
  parameter int NUM_OFFS    = CAP_LEN - EXP_LEN + 1,
  parameter int SW          = width_of(NUM_STREAMS),
  parameter int OW          = width_of(NUM_OFFS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   exp_load,
  input  logic [EXP_LEN-1:0]     exp_data,
  input  logic                   obs_valid,
  output logic                   obs_ready,
  input  logic [NUM_STREAMS-1:0] obs_bits,
  output logic                   done,
  output logic [6:0]             fitness_pct,
  output logic [SW-1:0]          best_stream,
  output logic [OW-1:0]          best_offset
);
  localparam int BW = width_of(CAP_LEN);
  localparam int CW = $clog2(EXP_LEN + 1);
  localparam int PW = CW + 7;

  fit_state_e state;
  logic [BW-1:0] beat_idx;
  logic          beat_we, score_en, score_first, fin;
  logic [OW-1:0] offset;
  logic [EXP_LEN-1:0] pattern_q;
  logic [NUM_STREAMS*CAP_LEN-1:0] cap;
  logic [CW-1:0] s_cnt [NUM_STREAMS];
  logic [OW-1:0] s_off [NUM_STREAMS];

  fit_ctrl #(.CAP_LEN(CAP_LEN), .NUM_OFFS(NUM_OFFS), .BW(BW), .OW(OW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .obs_valid   (obs_valid),
    .state_o     (state),
    .beat_idx    (beat_idx),
    .beat_we     (beat_we),
    .offset      (offset),
    .score_en    (score_en),
    .score_first (score_first),
    .fin         (fin)
  );

  assign obs_ready = (state == ST_CAPT);

  always_ff @(posedge clk) begin
    if (!rst_n)                              pattern_q <= '0;
    else if (exp_load && state == ST_IDLE)   pattern_q <= exp_data;
  end

  fit_capture #(.NUM_STREAMS(NUM_STREAMS), .CAP_LEN(CAP_LEN), .BW(BW)) u_cap (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (beat_we),
    .idx   (beat_idx),
    .bits  (obs_bits),
    .cap_o (cap)
  );

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_score
    fit_stream_best #(.EXP_LEN(EXP_LEN), .CAP_LEN(CAP_LEN), .OW(OW), .CW(CW)) u_best (
      .clk      (clk),
      .rst_n    (rst_n),
      .lane     (cap[s*CAP_LEN +: CAP_LEN]),
      .pattern  (pattern_q),
      .offset   (offset),
      .en       (score_en),
      .first    (score_first),
      .best_cnt (s_cnt[s]),
      .best_off (s_off[s])
    );
  end

  logic [CW-1:0] win_cnt;
  logic [SW-1:0] win_s;
  logic [OW-1:0] win_off;
  logic [PW-1:0] scaled;

  // strict comparison keeps the lowest stream index on a tie
  always_comb begin
    win_cnt = s_cnt[0];
    win_s   = '0;
    win_off = s_off[0];
    for (int s = 1; s < NUM_STREAMS; s++) begin
      if (s_cnt[s] > win_cnt) begin
        win_cnt = s_cnt[s];
        win_s   = SW'(s);
        win_off = s_off[s];
      end
    end
  end

  assign scaled = (PW'(win_cnt) * PW'(100)) / PW'(EXP_LEN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done        <= 1'b0;
      fitness_pct <= '0;
      best_stream <= '0;
      best_offset <= '0;
    end else begin
      done <= fin;
      if (fin) begin
        fitness_pct <= scaled[6:0];
        best_stream <= win_s;
        best_offset <= win_off;
      end
    end
  end
endmodule

// File: rtl/fit_window_scorer_chk.sv
module fit_window_scorer_chk #(
  parameter int NUM_OFFS = 11,
  parameter int SW       = 2,
  parameter int OW       = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          obs_valid,
  input logic          obs_ready,
  input logic          done,
  input logic [6:0]    fitness_pct,
  input logic [SW-1:0] best_stream,
  input logic [OW-1:0] best_offset
);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(fitness_pct) && $stable(best_stream) && $stable(best_offset)));

  a_r3_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(obs_ready) |-> $past(obs_valid));

  a_r2_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !obs_ready);

  a_r10_pct_range: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fitness_pct <= 7'd100));

  a_r10_offset_range: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(best_offset) <= NUM_OFFS - 1));
endmodule

bind fit_window_scorer fit_window_scorer_chk #(.NUM_OFFS(NUM_OFFS), .SW(SW), .OW(OW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .obs_valid   (obs_valid),
  .obs_ready   (obs_ready),
  .done        (done),
  .fitness_pct (fitness_pct),
  .best_stream (best_stream),
  .best_offset (best_offset)
);

// File: tb/fit_window_scorer_tb.sv
module fit_window_scorer_tb_top;
  localparam int EL = 100;
  localparam int CL = 110;
  localparam int NS = 4;
  localparam int NO = CL - EL + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic exp_load = 1'b0;
  logic [EL-1:0] exp_data = '0;
  logic obs_valid = 1'b0;
  logic obs_ready;
  logic [NS-1:0] obs_bits = '0;
  logic done;
  logic [6:0] fitness_pct;
  logic [1:0] best_stream;
  logic [3:0] best_offset;

  int total = 0;
  int bad = 0;

  logic [EL-1:0] ex;
  logic [CL-1:0] ob [NS];
  int m_pct, m_s, m_off;

  always #10 clk = ~clk;

  fit_window_scorer dut_i (
    .clk (clk), .rst_n (rst_n), .start (start), .exp_load (exp_load),
    .exp_data (exp_data), .obs_valid (obs_valid), .obs_ready (obs_ready),
    .obs_bits (obs_bits), .done (done), .fitness_pct (fitness_pct),
    .best_stream (best_stream), .best_offset (best_offset)
  );

  task automatic check(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic void model();
    m_pct = -1; m_s = 0; m_off = 0;
    for (int s = 0; s < NS; s++) begin
      int bc = -1, bo = 0;
      for (int k = 0; k < NO; k++) begin
        int c = 0;
        for (int i = 0; i < EL; i++) if (ex[i] == ob[s][i+k]) c++;
        if (c > bc) begin bc = c; bo = k; end
      end
      if (bc > m_pct) begin m_pct = bc; m_s = s; m_off = bo; end
    end
    m_pct = (m_pct * 100) / EL;
  endfunction

  task automatic load_exp(input logic [EL-1:0] v);
    @(negedge clk); exp_load = 1'b1; exp_data = v;
    @(negedge clk); exp_load = 1'b0;
  endtask

  // start a capture and feed CL beats; optional gaps and mid-run disturbances
  task automatic feed(input bit gaps, input bit disturb, output int accepted);
    int t = 0;
    accepted = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R2 ready after start", int'(obs_ready), 1);
    while (t < CL) begin
      logic rd;
      obs_valid = gaps ? (($urandom % 3) != 0) : 1'b1;
      for (int s = 0; s < NS; s++) obs_bits[s] = ob[s][t];
      if (disturb && t == 50) begin
        start = 1'b1; exp_load = 1'b1; exp_data = ~ex;
      end else begin
        start = 1'b0; exp_load = 1'b0;
      end
      rd = obs_ready;
      @(posedge clk);
      if (obs_valid && rd) begin t++; accepted++; end
      @(negedge clk);
    end
    obs_valid = 1'b0; start = 1'b0; exp_load = 1'b0;
  endtask

  task automatic finish_run(input string tag);
    int n = 0;
    logic [6:0] p; logic [1:0] s; logic [3:0] o;
    while (!done && n < 100) begin @(negedge clk); n++; end
    check({tag, " R8 done seen"}, int'(done), 1);
    model();
    check({tag, " R6 fitness"}, int'(fitness_pct), m_pct);
    check({tag, " R7 stream"}, int'(best_stream), m_s);
    check({tag, " R5 offset"}, int'(best_offset), m_off);
    p = fitness_pct; s = best_stream; o = best_offset;
    @(negedge clk);
    check({tag, " R8 done one cycle"}, int'(done), 0);
    repeat (3) @(negedge clk);
    check({tag, " R8 results held"}, int'({p, s, o} == {fitness_pct, best_stream, best_offset}), 1);
  endtask

  task automatic t_reset();
    check("R1 ready", int'(obs_ready), 0);
    check("R1 done", int'(done), 0);
    check("R1 results", int'({fitness_pct, best_stream, best_offset}), 0);
    obs_valid = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 no ready while idle", int'(obs_ready), 0);
    obs_valid = 1'b0;
  endtask

  task automatic t_exact();
    int acc;
    ex = {$urandom, $urandom, $urandom, $urandom};
    load_exp(ex);
    for (int s = 0; s < NS; s++) ob[s] = {$urandom, $urandom, $urandom, $urandom};
    ob[2] = {$urandom, $urandom, $urandom, $urandom};
    for (int i = 0; i < EL; i++) ob[2][i+3] = ex[i];
    feed(1'b0, 1'b0, acc);
    check("R3 beat count", acc, CL);
    check("R3 ready low after last", int'(obs_ready), 0);
    finish_run("exact");
    check("R5 exact offset 3", int'(best_offset), 3);
    check("R6 exact 100", int'(fitness_pct), 100);
  endtask

  task automatic t_gaps();
    int acc;
    for (int r = 0; r < 3; r++) begin
      for (int s = 0; s < NS; s++) ob[s] = {$urandom, $urandom, $urandom, $urandom};
      for (int i = 0; i < 40; i++) ob[r][i+7] = ex[i];
      feed(1'b1, 1'b0, acc);
      check("R3 gapped beat count", acc, CL);
      finish_run("gaps");
    end
  endtask

  task automatic t_ties();
    int acc;
    ex = '0;
    load_exp(ex);
    ob[0] = '1;
    ob[1] = '0; ob[1][2:0] = 3'b111;
    ob[2] = '0;
    ob[3] = '0;
    feed(1'b0, 1'b0, acc);
    finish_run("ties");
    check("R7 tie stream lowest", int'(best_stream), 1);
    check("R7 tie offset lowest", int'(best_offset), 3);
  endtask

  task automatic t_ignored();
    int acc;
    ex = {$urandom, $urandom, $urandom, $urandom};
    load_exp(ex);
    for (int s = 0; s < NS; s++) ob[s] = ~{ex, 10'h0};
    for (int i = 0; i < EL; i++) ob[3][i+10] = ex[i];
    feed(1'b0, 1'b1, acc);
    check("R9 start mid-capture keeps count", acc, CL);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    finish_run("ignored");
    check("R4 load during run ignored", int'(fitness_pct), 100);
    check("R9 no new capture", int'(obs_ready), 0);
    for (int s = 0; s < NS; s++) ob[s] = '0;
    ob[0][EL-1:0] = ex;
    feed(1'b0, 1'b0, acc);
    finish_run("persist");
    check("R4 pattern persists", int'(fitness_pct), 100);
  endtask

  task automatic t_low();
    int acc;
    for (int s = 0; s < NS; s++) ob[s] = {10'h0, ~ex} ^ {10'h0, ex} ^ {10'h3FF, ~ex};
    feed(1'b1, 1'b0, acc);
    finish_run("low");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_exact();
    t_gaps();
    t_ties();
    t_ignored();
    t_low();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule